// File: doc/BRIEF.md
# Frame Strip Packetizer

This block turns a square region of 8-bit pixels, held inside a wider frame buffer, into a sequence of byte packets. The region is split into horizontal bands of a few rows each. Every band becomes one packet. The packet opens with a single tag byte that carries the band's index, and the band's pixels follow row by row, left to right. A header stage further downstream wraps each packet for transport.

A one-cycle pulse on `start_i` launches a frame. The block then computes frame-buffer addresses and issues reads on a memory port whose latency is fixed. It aligns the returning bytes with their framing flags and queues them in a small buffer. The buffer drains into a valid/ready byte stream that marks the first and last byte of each packet. Reads are issued only while the buffer has room for every read still in flight, so backpressure at the output pauses address generation and no data is lost. When the last byte of the final band has been accepted, `busy_o` drops and `frame_done_o` pulses once.

With the defaults the region is 128x128 bytes. It is cut into 32 bands of 4 rows, so each packet holds 1 tag byte and 512 pixel bytes. The buffer row stride is 640 bytes, and the region's origin in the buffer is a parameter.

Top module: `strip_packetizer`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o`, `out_valid_o`, `mem_req_o` and `frame_done_o` are 0.
- R2: A `start_i` pulse while idle raises `busy_o` on the next cycle. The first byte delivered is the tag byte of band 0, and it has `out_sop_o`=1.
- R3: Each packet is 1 + FRAME_W*STRIP_ROWS bytes long. `out_sop_o` is 1 only on the first byte, which is the tag byte. `out_eop_o` is 1 only on the last pixel byte. Within a packet the two flags are never 1 together.
- R4: The tag byte of the packet for band s equals s, counting from 0. Bands are emitted in increasing order.
- R5: In band s, the pixel at row r (0..STRIP_ROWS-1) and column c (0..FRAME_W-1) is read from address ORIGIN + (s*STRIP_ROWS + r)*STRIDE + c. Pixels are emitted in that row-major order, and every read address lies inside the region.
- R6: The byte delivered for each pixel is the value that `mem_data_i` presents exactly RD_LAT cycles after the cycle in which `mem_req_o` was 1 with that address.
- R7: While `out_valid_o`=1 and `out_ready_i`=0, the next cycle keeps `out_valid_o`=1 with `out_data_o`, `out_sop_o` and `out_eop_o` unchanged. No byte is dropped or repeated.
- R8: When the output is held blocked long enough, `mem_req_o` stays 0 until space is freed. The internal queue never overflows.
- R9: One frame consists of exactly FRAME_H/STRIP_ROWS packets. In the cycle after the last byte of the last packet is accepted, `frame_done_o` is 1 for one cycle and `busy_o` is 0.
- R10: A `start_i` pulse while busy is ignored, and the frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame launch pulse |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | One-cycle pulse after the final byte |
| mem_req_o | output | 1 | Read request to frame buffer |
| mem_addr_o | output | ADDR_W | Read byte address |
| mem_data_i | input | 8 | Read data, RD_LAT cycles after request |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | First byte of packet (tag byte) |
| out_eop_o | output | 1 | Last byte of packet |

## Verification
The bench keeps the full 128x128 region, 4-row bands and 640-byte stride. It moves the origin to a non-zero offset in the middle of a row (row 37, column 201), so an address error in the base term or in the row term shows up as wrong pixel data. It sets RD_LAT to 3 instead of the default 2, so the alignment pipe and the credit limit are exercised at a depth other than the default. The bench runs whole frames with the output always ready, with pseudo-random ready, and with long stalls, so the buffer-full stop and the stable-hold behaviour are both reached.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef struct packed {
    logic       is_tag;
    logic       sop;
    logic       eop;
    logic [7:0] tag;
  } beat_tag_t;
endpackage

// File: rtl/strip_addr_gen.sv
module strip_addr_gen
  import strip_pkg::*;
#(
  parameter int unsigned FRAME_W    = 128,
  parameter int unsigned FRAME_H    = 128,
  parameter int unsigned STRIP_ROWS = 4,
  parameter int unsigned STRIDE     = 640,
  parameter int unsigned ORIGIN     = 0,
  parameter int unsigned ADDR_W     = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              adv_i,
  output logic              active_o,
  output beat_tag_t         tag_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned NUM_STRIPS = FRAME_H / STRIP_ROWS;
  localparam int unsigned COL_W   = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int unsigned ROW_W   = (STRIP_ROWS > 1) ? $clog2(STRIP_ROWS) : 1;
  localparam int unsigned STRIP_W = (NUM_STRIPS > 1) ? $clog2(NUM_STRIPS) : 1;
  localparam int unsigned ADDR_END = ORIGIN + (FRAME_H - 1) * STRIDE + FRAME_W;

  logic               active_q, tag_phase_q;
  logic [STRIP_W-1:0] strip_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic [ADDR_W-1:0]  base_q;
  logic last_col, last_row, last_strip;

  assign last_col   = col_q == COL_W'(FRAME_W - 1);
  assign last_row   = row_q == ROW_W'(STRIP_ROWS - 1);
  assign last_strip = strip_q == STRIP_W'(NUM_STRIPS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      tag_phase_q <= 1'b0;
      strip_q     <= '0;
      row_q       <= '0;
      col_q       <= '0;
      base_q      <= '0;
    end else if (launch_i) begin
      active_q    <= 1'b1;
      tag_phase_q <= 1'b1;
      strip_q     <= '0;
      row_q       <= '0;
      col_q       <= '0;
      base_q      <= ADDR_W'(ORIGIN);
    end else if (adv_i && active_q) begin
      if (tag_phase_q) begin
        tag_phase_q <= 1'b0;
      end else if (last_col) begin
        col_q  <= '0;
        base_q <= base_q + ADDR_W'(STRIDE);
        if (last_row) begin
          row_q       <= '0;
          tag_phase_q <= 1'b1;
          if (last_strip) active_q <= 1'b0;
          else            strip_q  <= strip_q + 1'b1;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign active_o   = active_q;
  assign addr_o     = base_q + ADDR_W'(col_q);
  assign tag_o.is_tag = tag_phase_q;
  assign tag_o.sop    = tag_phase_q;
  assign tag_o.eop    = !tag_phase_q && last_col && last_row;
  assign tag_o.tag    = 8'(strip_q);

  // R5
  addr_in_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tag_phase_q) |-> (32'(addr_o) >= ORIGIN && 32'(addr_o) < ADDR_END));
endmodule

// File: rtl/rd_align_pipe.sv
module rd_align_pipe #(
  parameter int unsigned LAT   = 2,
  parameter int unsigned TAG_W = 11,
  localparam int unsigned CNT_W = $clog2(LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [TAG_W-1:0] in_tag_i,
  output logic             out_valid_o,
  output logic [TAG_W-1:0] out_tag_o,
  output logic [CNT_W-1:0] inflight_o
);
  logic [LAT-1:0]   v_q;
  logic [TAG_W-1:0] t_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < int'(LAT); i++) t_q[i] <= '0;
    end else begin
      v_q[0] <= in_valid_i;
      t_q[0] <= in_tag_i;
      for (int i = 1; i < int'(LAT); i++) begin
        v_q[i] <= v_q[i-1];
        t_q[i] <= t_q[i-1];
      end
    end
  end

  always_comb begin
    inflight_o = '0;
    for (int i = 0; i < int'(LAT); i++) inflight_o = inflight_o + CNT_W'(v_q[i]);
  end

  assign out_valid_o = v_q[LAT-1];
  assign out_tag_o   = t_q[LAT-1];
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DW    = 10,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    din_i,
  input  logic             pop_i,
  output logic [DW-1:0]    dout_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign do_pop = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(do_pop);
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign empty_o = cnt_q == '0;
  assign cnt_o   = cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CNT_W'(DEPTH)));
endmodule

// File: rtl/strip_packetizer.sv
module strip_packetizer
  import strip_pkg::*;
#(
  parameter int unsigned FRAME_W    = 128,
  parameter int unsigned FRAME_H    = 128,
  parameter int unsigned STRIP_ROWS = 4,
  parameter int unsigned STRIDE     = 640,
  parameter int unsigned ORIGIN     = 0,
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned RD_LAT     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              frame_done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o
);
  localparam int unsigned NUM_STRIPS = FRAME_H / STRIP_ROWS;
  localparam int unsigned STRIP_W    = (NUM_STRIPS > 1) ? $clog2(NUM_STRIPS) : 1;
  localparam int unsigned FIFO_DEPTH = RD_LAT + 2;
  localparam int unsigned TAG_W      = $bits(beat_tag_t);
  localparam int unsigned FCNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned ICNT_W     = $clog2(RD_LAT + 1);

  logic               busy_q, done_q, launch, issue, gen_active;
  beat_tag_t          gen_tag, pipe_tag;
  logic [TAG_W-1:0]   pipe_bits;
  logic               pipe_valid;
  logic [ICNT_W-1:0]  inflight;
  logic [FCNT_W-1:0]  fifo_cnt;
  logic [9:0]         fifo_din, fifo_dout;
  logic               fifo_empty, pop, last_accept;
  logic [STRIP_W-1:0] out_strip_q;

  assign launch = start_i && !busy_q;
  assign issue  = gen_active && (int'(fifo_cnt) + int'(inflight) < int'(FIFO_DEPTH));

  strip_addr_gen #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .STRIP_ROWS(STRIP_ROWS),
    .STRIDE(STRIDE), .ORIGIN(ORIGIN), .ADDR_W(ADDR_W)
  ) u_gen (
    .clk_i, .rst_ni, .launch_i(launch), .adv_i(issue),
    .active_o(gen_active), .tag_o(gen_tag), .addr_o(mem_addr_o)
  );

  assign mem_req_o = issue && !gen_tag.is_tag;

  rd_align_pipe #(.LAT(RD_LAT), .TAG_W(TAG_W)) u_pipe (
    .clk_i, .rst_ni, .in_valid_i(issue), .in_tag_i(gen_tag),
    .out_valid_o(pipe_valid), .out_tag_o(pipe_bits), .inflight_o(inflight)
  );

  assign pipe_tag = beat_tag_t'(pipe_bits);
  assign fifo_din = {pipe_tag.sop, pipe_tag.eop,
                     pipe_tag.is_tag ? pipe_tag.tag : mem_data_i};

  byte_fifo #(.DW(10), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(pipe_valid), .din_i(fifo_din), .pop_i(pop),
    .dout_o(fifo_dout), .empty_o(fifo_empty), .cnt_o(fifo_cnt)
  );

  assign out_valid_o = !fifo_empty;
  assign out_sop_o   = fifo_dout[9];
  assign out_eop_o   = fifo_dout[8];
  assign out_data_o  = fifo_dout[7:0];
  assign pop         = out_valid_o && out_ready_i;
  assign last_accept = pop && out_eop_o && (out_strip_q == STRIP_W'(NUM_STRIPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      out_strip_q <= '0;
    end else begin
      done_q <= last_accept;
      if (launch) begin
        busy_q      <= 1'b1;
        out_strip_q <= '0;
      end else begin
        if (last_accept) busy_q <= 1'b0;
        if (pop && out_eop_o) out_strip_q <= out_strip_q + 1'b1;
      end
    end
  end

  assign busy_o       = busy_q;
  assign frame_done_o = done_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !out_valid_o));
  // R3
  sop_eop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_sop_o && out_eop_o));
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_sop_o) && $stable(out_eop_o)));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

// File: tb/tb_strip_packetizer.sv
module tb_strip_packetizer;
  localparam int W = 128, H = 128, ROWS = 4, STRIDE = 640;
  localparam int ORIGIN = 640 * 37 + 201;
  localparam int AW = 19, LAT = 3;
  localparam int NSTRIP = H / ROWS, PKT = 1 + W * ROWS;

  logic clk = 0, rst_n = 0, start = 0, ready = 0;
  logic busy, done, req, valid, sop, eop;
  logic [AW-1:0] addr;
  logic [7:0] mdata, odata;
  logic [7:0] mpipe [LAT];

  int checks = 0, failures = 0, cycles = 0;
  int exp_s = 0, exp_k = 0, beats = 0, frames_done = 0;
  logic due_done = 0, prev_stall = 0, prev_sop = 0, prev_eop = 0;
  logic [7:0] prev_data = 0;

  always #2 clk = ~clk;

  strip_packetizer #(.ORIGIN(ORIGIN), .ADDR_W(AW), .RD_LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .frame_done_o(done),
    .mem_req_o(req), .mem_addr_o(addr), .mem_data_i(mdata),
    .out_valid_o(valid), .out_ready_i(ready), .out_data_o(odata),
    .out_sop_o(sop), .out_eop_o(eop));

  function automatic logic [7:0] pix(int a);
    return 8'((a * 13) ^ (a >> 7));
  endfunction

  // memory model: data RD_LAT cycles after request (R6)
  always @(posedge clk) begin
    mpipe[0] <= req ? pix(int'(addr)) : 8'h00;
    for (int i = 1; i < LAT; i++) mpipe[i] <= mpipe[i-1];
  end
  assign mdata = mpipe[LAT-1];

  task automatic chk(input bit ok, input string req_s, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req_s, act, exp);
    end
  endtask

  // stream monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (due_done) begin
        chk(done === 1'b1, "R9 frame_done pulse", done, 1);
        chk(busy === 1'b0, "R9 busy low after frame", busy, 0);
        frames_done++;
        due_done = 0;
      end else if (done) chk(0, "R9 spurious frame_done", 1, 0);
      if (prev_stall)
        chk(valid && odata == prev_data && sop == prev_sop && eop == prev_eop,
            "R7 hold while stalled", int'(odata), int'(prev_data));
      if (valid && ready) begin
        int ed, es, ee;
        if (exp_k == 0) begin
          ed = exp_s; es = 1; ee = 0;
          chk(int'(odata) == ed, "R4 tag byte", odata, ed);
        end else begin
          int p, r, c;
          p = exp_k - 1; r = p / W; c = p % W;
          ed = int'(pix(ORIGIN + (exp_s * ROWS + r) * STRIDE + c));
          es = 0; ee = (exp_k == PKT - 1);
          chk(int'(odata) == ed, "R5 R6 pixel data", odata, ed);
        end
        chk(int'(sop) == es && int'(eop) == ee, "R3 framing flags",
            {sop, eop}, {es[0], ee[0]});
        beats++;
        if (exp_k == PKT - 1) begin
          exp_k = 0;
          if (exp_s == NSTRIP - 1) begin exp_s = 0; due_done = 1; end
          else exp_s++;
        end else exp_k++;
      end
      prev_stall = valid && !ready;
      prev_data = odata; prev_sop = sop; prev_eop = eop;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      chk(0, "watchdog", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic test_reset();
    #1 chk(!busy && !valid && !req && !done, "R1 reset outputs", {busy, valid, req, done}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1 chk(!busy && !valid && !req && !done, "R1 idle outputs", {busy, valid, req, done}, 0);
  endtask

  // mode 0: always ready, 1: pseudo-random ready, 2: long stalls + restart attempt
  task automatic run_frame(input int mode);
    int f0, b0, n;
    logic [15:0] lfsr;
    f0 = frames_done; b0 = beats; n = 0; lfsr = 16'hACE1;
    ready = (mode != 2);
    pulse_start();
    #1 chk(busy === 1'b1, "R2 busy after start", busy, 1);
    while (frames_done == f0) begin
      @(posedge clk); #1;
      n++;
      if (mode == 1) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ready = lfsr[0];
      end else if (mode == 2) begin
        ready = (n % 700) >= 40;
        if (n % 700 == 30) begin
          chk(req === 1'b0 && valid === 1'b1, "R8 reads stop when blocked", req, 0);
          if (n == 730) begin
            start = 1; @(posedge clk); #1 start = 0;
            chk(busy === 1'b1, "R10 start ignored while busy", busy, 1);
          end
        end
      end
    end
    chk(beats - b0 == NSTRIP * PKT, "R9 bytes per frame", beats - b0, NSTRIP * PKT);
    ready = 1;
    repeat (5) @(posedge clk);
    #1 chk(!busy && !valid && !req, "R1 idle after frame", {busy, valid, req}, 0);
  endtask

  task automatic test_first_byte();
    ready = 0;
    pulse_start();
    repeat (LAT + 3) @(posedge clk);
    #1 chk(valid && sop && odata == 8'd0, "R2 first byte is tag 0", odata, 0);
    ready = 1;
    while (!done) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    test_reset();
    run_frame(0);
    run_frame(1);
    run_frame(2);
    test_first_byte();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule